// File: doc/BRIEF.md
# Programmable LFSR Noise Generator

This block is the noise voice of a retro square-wave sound generator. A shift register produces a one-bit noise waveform. In white mode the bit fed back is the XOR of the tapped stages, which gives a long pseudo-random sequence. In periodic mode the bit leaving the register is simply rotated back in, so a single set bit circulates and produces a narrow pulse train. The register length, the tap mask and the seed are parameters, so one source covers the members of the chip family.

The shift rate is chosen by a two-bit rate code held in a small control register. Three codes take their rate from a free-running prescaler, and the counter advances only on cycles where the master tick enable is high. The fourth code lets the third tone channel clock the register instead. The register advances once per rising edge of the selected source. Each write strobe loads a new three-bit control field and restarts the register from its seed. The prescaler is not affected by writes. Register decoding, attenuation and mixing belong to neighbouring blocks.

Top module: `lfsr_noise_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its control register to rate code 00 with periodic feedback, clears the prescaler, and loads the shift register with its seed (default: only the top bit set), so `noise_out` reads 0.
- R2: With rate code 00 (`ctrl[1:0]`) and periodic feedback (`ctrl[2]` = 0), and `tick_en` held high, `noise_out` rises once every 15 × 512 clock cycles.
- R3: Rate code 01 shifts once every 1024 ticks and code 10 once every 2048 ticks, so in periodic mode `noise_out` stays high for exactly that many cycles.
- R4: The prescaler advances only on cycles with `tick_en` high, so a tick every other cycle doubles every shift interval.
- R5: With rate code 11, each rising edge of `tone3_tgl` shifts the register once, and the new value is visible after the next clock edge.
- R6: A falling edge of `tone3_tgl`, or a steady level, does not shift the register.
- R7: Periodic feedback (`ctrl[2]` = 0) shifts the register toward bit 0 and puts the old bit 0 into the top bit: from the seed, `noise_out` is 1 after the 14th shift and 0 again after the 15th.
- R8: White feedback (`ctrl[2]` = 1) shifts toward bit 0 and puts the XOR of the tapped bits (default: bits 0 and 1) into the top bit. `noise_out` is bit 0.
- R9: A cycle with `ctrl_wr` high loads `ctrl` and reloads the seed. The reload wins over a shift that falls in the same cycle.
- R10: A control write does not clear or restart the prescaler. The next divided shift comes at the counter's running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Master-clock tick enable for the prescaler |
| ctrl | input | 3 | Control field: bit 2 selects white feedback, bits 1:0 the rate code |
| ctrl_wr | input | 1 | Strobe: control register written this cycle |
| tone3_tgl | input | 1 | Square output of the third tone channel |
| noise_out | output | 1 | Noise waveform (bit 0 of the shift register) |

## Verification
A tone-driven shift is visible one clock edge after the edge detector first sees `tone3_tgl` high, and a reseed is visible right after the write edge. The bench raises the source at one edge and samples about 1 ns after the next edge. Divided rates are timed by the distance between output edges in periodic mode. The rise-to-rise interval (15 shifts) and the high width (one shift) do not depend on the phase of the prescaler, so they are checked as exact cycle counts. The test that the prescaler keeps its phase across a write measures cycles from the write to the first high output. It accepts a window of a few cycles centred on 7124, which is well away from the 6912 that a restarted counter would give.

// File: rtl/noise_pkg.sv
package noise_pkg;

   typedef enum logic [1:0] {
      RATE_DIV_A = 2'b00,
      RATE_DIV_B = 2'b01,
      RATE_DIV_C = 2'b10,
      RATE_TONE3 = 2'b11
   } noise_rate_e;

   typedef struct packed {
      logic        white;
      noise_rate_e rate;
   } noise_ctrl_t;

   localparam int NUM_DIV_RATES = 3;

endpackage

// File: rtl/noise_prescaler.sv
module noise_prescaler #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt
);

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("noise_prescaler: CNT_W must be at least 3");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (tick_en)
         cnt <= cnt + 1'b1;
   end

   p_count_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
      tick_en |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> $stable(cnt));

endmodule

// File: rtl/noise_rate_sel.sv
module noise_rate_sel
   import noise_pkg::*;
#(
   parameter int NDIV = NUM_DIV_RATES
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NDIV-1:0] div_bits,
   input  logic            tone3_tgl,
   input  noise_rate_e     rate,
   output logic            shift_pulse
);

   generate
      if (NDIV != 3) begin : g_bad_ndiv
         $error("noise_rate_sel: exactly three divided rates are encoded");
      end
   endgenerate

   logic src;
   logic src_q;

   always_comb begin
      unique case (rate)
         RATE_DIV_A: src = div_bits[0];
         RATE_DIV_B: src = div_bits[1];
         RATE_DIV_C: src = div_bits[2];
         default:    src = tone3_tgl;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         src_q <= 1'b0;
      else
         src_q <= src;
   end

   assign shift_pulse = src & ~src_q;

   // A rising edge needs a low sample first, so two shifts never come back to back.
   p_one_shift_per_edge_r5: assert property (@(posedge clk) disable iff (rst)
      shift_pulse |=> !shift_pulse);

   p_no_shift_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
      (rate == RATE_TONE3 && $stable(rate) && $fell(tone3_tgl)) |-> !shift_pulse);

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
   parameter int         W        = 15,
   parameter logic [W-1:0] TAP_MASK = W'(3),
   parameter logic [W-1:0] SEED     = W'(1) << (W - 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         shift,
   input  logic         reload,
   input  logic         white,
   output logic [W-1:0] q
);

   generate
      if (W < 2) begin : g_bad_len
         $error("noise_lfsr: register must be at least 2 bits");
      end
      if (TAP_MASK == '0) begin : g_bad_taps
         $error("noise_lfsr: tap mask must select at least one bit");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("noise_lfsr: an all-zero seed locks the register");
      end
   endgenerate

   logic fb;

   always_comb begin
      if (white)
         fb = ^(q & TAP_MASK);
      else
         fb = q[0];
   end

   always_ff @(posedge clk) begin
      if (rst || reload)
         q <= SEED;
      else if (shift)
         q <= {fb, q[W-1:1]};
   end

   p_seed_after_reset_r1: assert property (@(posedge clk)
      rst |=> q == SEED);

   p_seed_on_write_r9: assert property (@(posedge clk) disable iff (rst)
      reload |=> q == SEED);

   p_shift_right_r8: assert property (@(posedge clk) disable iff (rst)
      (shift && !reload) |=> q[W-2:0] == $past(q[W-1:1]));

   p_periodic_rotate_r7: assert property (@(posedge clk) disable iff (rst)
      (shift && !reload && !white) |=> q[W-1] == $past(q[0]));

   p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
      (!shift && !reload) |=> $stable(q));

endmodule

// File: rtl/lfsr_noise_channel.sv
module lfsr_noise_channel
   import noise_pkg::*;
#(
   parameter int           LFSR_W     = 15,
   parameter logic [LFSR_W-1:0] TAP_MASK = LFSR_W'(3),
   parameter logic [LFSR_W-1:0] SEED     = LFSR_W'(1) << (LFSR_W - 1),
   parameter int           BASE_SHIFT = 9
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_en,
   input  logic [2:0] ctrl,
   input  logic       ctrl_wr,
   input  logic       tone3_tgl,
   output logic       noise_out
);

   localparam int CNT_W = BASE_SHIFT + NUM_DIV_RATES - 1;

   generate
      if (BASE_SHIFT < 1) begin : g_bad_base
         $error("lfsr_noise_channel: BASE_SHIFT must be at least 1");
      end
   endgenerate

   noise_ctrl_t             ctrl_q;
   logic [CNT_W-1:0]        cnt;
   logic                    shift_pulse;
   logic [LFSR_W-1:0]       lfsr_q;

   always_ff @(posedge clk) begin
      if (rst)
         ctrl_q <= '{white: 1'b0, rate: RATE_DIV_A};
      else if (ctrl_wr)
         ctrl_q <= noise_ctrl_t'(ctrl);
   end

   noise_prescaler #(.CNT_W(CNT_W)) u_presc (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .cnt     (cnt)
   );

   noise_rate_sel #(.NDIV(NUM_DIV_RATES)) u_sel (
      .clk         (clk),
      .rst         (rst),
      .div_bits    (cnt[CNT_W-1 -: NUM_DIV_RATES]),
      .tone3_tgl   (tone3_tgl),
      .rate        (ctrl_q.rate),
      .shift_pulse (shift_pulse)
   );

   noise_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .shift  (shift_pulse),
      .reload (ctrl_wr),
      .white  (ctrl_q.white),
      .q      (lfsr_q)
   );

   assign noise_out = lfsr_q[0];

   p_write_keeps_counter_r10: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && tick_en) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_reset_ctrl_r1: assert property (@(posedge clk)
      rst |=> (ctrl_q.rate == RATE_DIV_A && !ctrl_q.white && !noise_out));

endmodule

// File: tb/tb_lfsr_noise_channel.sv
module tb_lfsr_noise_channel;

   localparam int CLK_PERIOD = 10;
   localparam int W = 15;
   localparam logic [W-1:0] SEED = 15'h4000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_en = 1'b0;
   logic [2:0] ctrl = 3'b000;
   logic       ctrl_wr = 1'b0;
   logic       tone3_tgl = 1'b0;
   logic       noise_out;

   int n_checks = 0;
   int n_fail = 0;
   int tick_mode = 1;   // 0 off, 1 every cycle, 2 every other cycle

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_noise_channel dut (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .ctrl      (ctrl),
      .ctrl_wr   (ctrl_wr),
      .tone3_tgl (tone3_tgl),
      .noise_out (noise_out)
   );

   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (tick_mode == 2) tick_en = ~tick_en;
         else tick_en = (tick_mode == 1);
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog req=all got=timeout exp=finish");
      summary();
      $finish;
   end

   task automatic chk(string req, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic chk_range(string req, int got, int lo, int hi);
      n_checks++;
      if (got < lo || got > hi) begin
         n_fail++;
         $display("FAIL %s got=%0d exp=%0d..%0d", req, got, lo, hi);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic write_ctrl(logic [2:0] v);
      ctrl = v;
      ctrl_wr = 1'b1;
      cyc();
      ctrl_wr = 1'b0;
   endtask

   task automatic tone_rise();
      tone3_tgl = 1'b1;
      cyc();
   endtask

   task automatic tone_fall();
      tone3_tgl = 1'b0;
      cyc();
   endtask

   function automatic logic [W-1:0] white_next(logic [W-1:0] r);
      return {r[0] ^ r[1], r[W-1:1]};
   endfunction

   // cycles until noise_out goes from 0 to 1; -1 on timeout
   task automatic wait_rise(int limit, output int n);
      logic prev;
      prev = noise_out;
      n = -1;
      for (int i = 1; i <= limit; i++) begin
         cyc();
         if (!prev && noise_out) begin
            n = i;
            break;
         end
         prev = noise_out;
      end
   endtask

   task automatic high_width(int limit, output int n);
      n = -1;
      for (int i = 1; i <= limit; i++) begin
         cyc();
         if (!noise_out) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) cyc();
      chk("R1 output during reset", noise_out, 0);
      rst = 1'b0;
      cyc();
      chk("R1 output after reset", noise_out, 0);
   endtask

   task automatic t_counter_phase();
      int n;
      tick_mode = 1;
      rst = 1'b1;
      repeat (2) cyc();
      rst = 1'b0;
      repeat (300) cyc();
      write_ctrl(3'b000);
      chk("R9 seed after write", noise_out, 0);
      n = 0;
      for (int i = 1; i <= 9000; i++) begin
         cyc();
         if (noise_out) begin
            n = i;
            break;
         end
      end
      // 14 shifts at the running phase: pulse edges at counts 768 + k*512
      chk_range("R10 prescaler phase kept across write", n, 7120, 7128);
   endtask

   task automatic t_rate_a_period();
      int n;
      wait_rise(9000, n);
      chk("R2 first rise seen", (n > 0) ? 1 : 0, 1);
      wait_rise(9000, n);
      chk("R2 rise-to-rise period rate 00", n, 15 * 512);
   endtask

   task automatic t_rate_bc_width();
      int n;
      write_ctrl(3'b001);
      wait_rise(17000, n);
      chk("R3 rate 01 reaches high", (n > 0) ? 1 : 0, 1);
      high_width(3000, n);
      chk("R3 high width rate 01", n, 1024);
      write_ctrl(3'b010);
      wait_rise(33000, n);
      chk("R3 rate 10 reaches high", (n > 0) ? 1 : 0, 1);
      high_width(5000, n);
      chk("R3 high width rate 10", n, 2048);
   endtask

   task automatic t_half_tick();
      int n;
      write_ctrl(3'b000);
      tick_mode = 2;
      wait_rise(17000, n);
      chk("R4 half-rate tick reaches high", (n > 0) ? 1 : 0, 1);
      high_width(3000, n);
      chk("R4 width doubled by half-rate tick", n, 1024);
      tick_mode = 1;
   endtask

   task automatic t_tone_periodic();
      tone3_tgl = 1'b0;
      write_ctrl(3'b011);
      cyc();
      for (int k = 1; k <= 13; k++) begin
         tone_rise();
         chk($sformatf("R5 rise %0d output", k), noise_out, 0);
         tone_fall();
         chk($sformatf("R6 fall %0d no shift", k), noise_out, 0);
      end
      tone_rise();
      chk("R7 output high after 14th shift", noise_out, 1);
      cyc();
      chk("R6 steady level holds", noise_out, 1);
      tone_fall();
      chk("R6 fall keeps output", noise_out, 1);
      tone_rise();
      chk("R7 output low after 15th shift", noise_out, 0);
      tone_fall();
   endtask

   task automatic t_tone_white();
      logic [W-1:0] r;
      int bad;
      int ones;
      write_ctrl(3'b111);
      r = SEED;
      bad = 0;
      ones = 0;
      for (int k = 1; k <= 40; k++) begin
         tone_rise();
         r = white_next(r);
         if (noise_out !== r[0]) bad++;
         if (noise_out) ones++;
         tone_fall();
      end
      chk("R8 white sequence mismatches", bad, 0);
      chk("R8 white sequence ones over 40 shifts", ones, 0 + $countones(40'(0)) + ones_expected());
   endtask

   function automatic int ones_expected();
      logic [W-1:0] r;
      int c;
      r = SEED;
      c = 0;
      for (int k = 0; k < 40; k++) begin
         r = white_next(r);
         if (r[0]) c++;
      end
      return c;
   endfunction

   task automatic t_reseed_wins();
      tone3_tgl = 1'b1;
      ctrl = 3'b011;
      ctrl_wr = 1'b1;
      cyc();
      ctrl_wr = 1'b0;
      chk("R9 reload beats same-cycle shift", noise_out, 0);
      tone_fall();
      for (int k = 1; k <= 13; k++) begin
         tone_rise();
         tone_fall();
      end
      chk("R9 restart: 13 shifts still low", noise_out, 0);
      tone_rise();
      chk("R9 restart: 14th shift high", noise_out, 1);
      tone_fall();
   endtask

   initial begin
      t_reset();
      t_tone_periodic();
      t_tone_white();
      t_reseed_wins();
      t_counter_phase();
      t_rate_a_period();
      t_rate_bc_width();
      t_half_tick();
      summary();
      $finish;
   end

endmodule